// File: doc/BRIEF.md
# Permuted Multi-Bank Vector Scratchpad

The block is a scratchpad of 16-bit elements spread over four physical banks. Each request carries four logical element addresses, one per lane, and a lane enable for each. Any pattern of addresses is accepted: an aligned row of a 4x4 tile, a column, an unaligned run, or an arbitrary gather. A per-lane address mapper turns each logical address into a bank and a bank row, and a crossbar moves data between lanes and banks. When enabled lanes collide on one bank, a scheduler serves them over several cycles. A request is held with `req_valid` until the block raises `req_ready`, and read data comes back in lane order.

The mapping mode is sampled with each request, so one piece of hardware can be measured as a single wide memory, a plainly interleaved memory, or a permuted memory. In the permuted mode a tile's rows and its columns both spread over four distinct banks. `cycle_count` reports how many bank cycles the most recent access used.

The controller has four states. ST_IDLE waits for a request. The transition *accept* leads to ST_ISSUE when any lane is enabled, and *accept-empty* leads to ST_FLUSH when none is. ST_ISSUE grants at most one lane per bank on each cycle. The transition *last-grant* leads to ST_FLUSH on the cycle that leaves no lane pending. ST_FLUSH takes in the final bank read data and always moves on through *drain* to ST_DONE. ST_DONE raises `req_ready`, and through *complete* returns to ST_IDLE.

Top module: `pmb_vecmem`

## Requirements
- R1: While and after reset, before any request, `req_ready` and `rd_valid` are 0 and `cycle_count` is 0.
- R2: A request is taken on the rising edge where `req_valid` is high in ST_IDLE. For an access costing N bank cycles, `req_ready` is high for exactly one cycle, and that cycle follows the (N+2)-th rising edge counted from the accepting edge inclusive. While `req_ready` is high no bank is driven.
- R3: For a read, `rd_valid` is high only together with `req_ready`. `rd_data` lane i, at bits [16i+15:16i], holds the element at lane i's logical address, whatever bank it came from. For a write, `rd_valid` stays 0.
- R4: `cycle_count` equals the number of bank cycles of the most recent access, never exceeds 4, and holds its value from `req_ready` until the next request is accepted.
- R5: Mode 0 (single wide memory): each cycle serves the pending lanes whose addresses lie in the same aligned 4-element group (a>>2) as the lowest-numbered pending lane. An aligned row costs 1 cycle, a column costs 4, and the run {1,2,3,4} costs 2. This mode shares its data placement with mode 1.
- R6: Mode 1 (interleaved): bank = a[1:0], bank row = a>>2. Cost is the largest number of enabled lanes sharing a bank. Any contiguous run {x..x+3} costs 1, and a column {c,c+4,c+8,c+12} costs 4.
- R7: Modes 2 and 3 (permuted): bank = (a[1:0]+a[3:2]) mod 4, bank row = a>>2, repeated for every 16-element tile. Aligned rows and columns of every tile cost 1, and the run {1,2,3,4} costs 2.
- R8: A disabled lane neither writes nor occupies a bank. It adds nothing to the cost, and on a read its `rd_data` lane is 0. A request with no enabled lane costs 0 cycles.
- R9: When enabled write lanes share an address, lanes are written in ascending order, so the value of the highest-numbered such lane remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held with its fields until `req_ready` |
| req_ready | output | 1 | One-cycle pulse: request fully served |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | 0 single, 1 interleaved, 2 or 3 permuted |
| req_lane_en | input | 4 | Per-lane enable, bit i for lane i |
| req_addr | input | 4*AW | Lane i logical address at bits [AW*i +: AW], AW = log2(DEPTH) |
| req_wdata | input | 64 | Lane i write data at bits [16*i +: 16] |
| rd_valid | output | 1 | Read data valid, only with `req_ready` |
| rd_data | output | 64 | Read data in lane order |
| cycle_count | output | 3 | Bank cycles spent by the most recent access |

## Verification
The checks assume the requester keeps `req_valid` and every request field stable from the accepting edge until `req_ready`, and lowers or changes them only after the completing cycle. The bench drives all inputs on falling edges, holds each request until it sees `req_ready`, and drops `req_valid` in that same cycle. Memory contents are left unreset, so every read targets addresses that an earlier write filled under a mode with the same placement. The whole space is written again before the switch to the permuted mode.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
    localparam int LANES  = 4;
    localparam int BANK_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FLUSH = 2'd2,
        ST_DONE  = 2'd3
    } state_e;

    localparam logic [1:0] MODE_SINGLE = 2'd0;
endpackage

// File: rtl/pmb_addr_map.sv
module pmb_addr_map #(
    parameter int AW = 6
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    mode,
    output logic [1:0]    bank,
    output logic [AW-3:0] row
);
    always_comb begin
        row = addr[AW-1:2];
        if (mode[1]) bank = addr[1:0] + addr[3:2];
        else         bank = addr[1:0];
    end
endmodule

// File: rtl/pmb_sched.sv
module pmb_sched
    import pmb_pkg::*;
#(
    parameter int ROW_W = 4
) (
    input  logic [LANES-1:0]              pending,
    input  logic [LANES-1:0][BANK_W-1:0]  bank,
    input  logic [LANES-1:0][ROW_W-1:0]   row,
    input  logic                          single,
    output logic [LANES-1:0]              grant
);
    logic [ROW_W-1:0] lead_row;
    logic             found;
    logic [LANES-1:0] elig;
    logic             blocked;

    always_comb begin
        lead_row = '0;
        found    = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            if (pending[l] && !found) begin
                lead_row = row[l];
                found    = 1'b1;
            end
        end
        for (int l = 0; l < LANES; l++)
            elig[l] = pending[l] && (!single || row[l] == lead_row);
        for (int l = 0; l < LANES; l++) begin
            blocked = 1'b0;
            for (int j = 0; j < LANES; j++)
                if (j < l && elig[j] && bank[j] == bank[l]) blocked = 1'b1;
            grant[l] = elig[l] && !blocked;
        end
    end
endmodule

// File: rtl/pmb_bank.sv
module pmb_bank #(
    parameter int ELEM_W = 16,
    parameter int ROWS   = 16,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [ELEM_W-1:0] wdata,
    output logic [ELEM_W-1:0] q
);
    logic [ELEM_W-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[row] <= wdata;
            else    q <= mem[row];
        end
    end
endmodule

// File: rtl/pmb_vecmem.sv
module pmb_vecmem
    import pmb_pkg::*;
#(
    parameter int ELEM_W = 16,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int ROW_W = AW - 2,
    localparam int ROWS  = DEPTH / LANES,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [1:0]              req_mode,
    input  logic [LANES-1:0]        req_lane_en,
    input  logic [LANES*AW-1:0]     req_addr,
    input  logic [LANES*ELEM_W-1:0] req_wdata,
    output logic                    rd_valid,
    output logic [LANES*ELEM_W-1:0] rd_data,
    output logic [CNT_W-1:0]        cycle_count
);
    state_e state, state_nx;

    logic [1:0]                         mode_q;
    logic                               write_q;
    logic [LANES-1:0][AW-1:0]           addr_q;
    logic [LANES-1:0][ELEM_W-1:0]       wdata_q;
    logic [LANES-1:0]                   pending;
    logic [CNT_W-1:0]                   cnt;
    logic [LANES-1:0]                   cap_valid;
    logic [LANES-1:0][BANK_W-1:0]       cap_bank;
    logic [LANES-1:0][ELEM_W-1:0]       res;

    logic [LANES-1:0][BANK_W-1:0]       lane_bank;
    logic [LANES-1:0][ROW_W-1:0]        lane_row;
    logic [LANES-1:0]                   grant;
    logic [LANES-1:0]                   issue;
    logic [LANES-1:0]                   bank_en;
    logic [LANES-1:0][ROW_W-1:0]        bank_row;
    logic [LANES-1:0][ELEM_W-1:0]       bank_wd;
    logic [LANES-1:0][ELEM_W-1:0]       bank_q;

    wire accept = (state == ST_IDLE) && req_valid;

    for (genvar l = 0; l < LANES; l++) begin : g_map
        pmb_addr_map #(.AW(AW)) u_map (
            .addr (addr_q[l]),
            .mode (mode_q),
            .bank (lane_bank[l]),
            .row  (lane_row[l])
        );
    end

    pmb_sched #(.ROW_W(ROW_W)) u_sched (
        .pending (pending),
        .bank    (lane_bank),
        .row     (lane_row),
        .single  (mode_q == MODE_SINGLE),
        .grant   (grant)
    );

    assign issue = (state == ST_ISSUE) ? grant : '0;

    // crossbar: lanes to banks
    always_comb begin
        bank_en  = '0;
        bank_row = '0;
        bank_wd  = '0;
        for (int b = 0; b < LANES; b++) begin
            for (int l = 0; l < LANES; l++) begin
                if (issue[l] && lane_bank[l] == BANK_W'(b)) begin
                    bank_en[b]  = 1'b1;
                    bank_row[b] = lane_row[l];
                    bank_wd[b]  = wdata_q[l];
                end
            end
        end
    end

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        pmb_bank #(.ELEM_W(ELEM_W), .ROWS(ROWS)) u_bank (
            .clk   (clk),
            .en    (bank_en[b]),
            .we    (write_q),
            .row   (bank_row[b]),
            .wdata (bank_wd[b]),
            .q     (bank_q[b])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = (req_lane_en == '0) ? ST_FLUSH : ST_ISSUE;
            ST_ISSUE: if ((pending & ~grant) == '0) state_nx = ST_FLUSH;
            ST_FLUSH: state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rd_valid  = 1'b0;
        unique case (state)
            ST_IDLE, ST_ISSUE, ST_FLUSH: ;
            ST_DONE: begin
                req_ready = 1'b1;
                rd_valid  = !write_q;
            end
        endcase
    end

    assign rd_data     = res;
    assign cycle_count = cnt;

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            write_q   <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            pending   <= '0;
            cnt       <= '0;
            cap_valid <= '0;
            cap_bank  <= '0;
            res       <= '0;
        end else begin
            for (int l = 0; l < LANES; l++)
                if (cap_valid[l]) res[l] <= bank_q[cap_bank[l]];
            if (accept) begin
                mode_q    <= req_mode;
                write_q   <= req_write;
                addr_q    <= req_addr;
                wdata_q   <= req_wdata;
                pending   <= req_lane_en;
                cnt       <= '0;
                res       <= '0;
                cap_valid <= '0;
            end else if (state == ST_ISSUE) begin
                pending   <= pending & ~grant;
                cnt       <= cnt + CNT_W'(1);
                cap_valid <= write_q ? '0 : grant;
                cap_bank  <= lane_bank;
            end else begin
                cap_valid <= '0;
            end
        end
    end
endmodule

// File: rtl/pmb_vecmem_chk.sv
module pmb_vecmem_chk #(
    parameter int LANES = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rd_valid,
    input logic [CNT_W-1:0] cycle_count,
    input logic [LANES-1:0] bank_en
);
    p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    p_idle_banks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bank_en == '0));

    p_rdvalid_with_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> req_ready);

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_count <= CNT_W'(LANES));

    p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> $stable(cycle_count));
endmodule

bind pmb_vecmem pmb_vecmem_chk #(.LANES(pmb_pkg::LANES), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rd_valid    (rd_valid),
    .cycle_count (cycle_count),
    .bank_en     (bank_en)
);

// File: tb/tb_pmb_vecmem.sv
module tb_pmb_vecmem;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int AW = 6;
    localparam int EW = 16;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           req_valid;
    logic           req_ready;
    logic           req_write;
    logic [1:0]     req_mode;
    logic [3:0]     req_lane_en;
    logic [4*AW-1:0] req_addr;
    logic [4*EW-1:0] req_wdata;
    logic           rd_valid;
    logic [4*EW-1:0] rd_data;
    logic [2:0]     cycle_count;

    int checks = 0;
    int errors = 0;
    logic [EW-1:0] model [DEPTH];

    logic [4*EW-1:0] got_data;
    logic            got_valid;
    logic [2:0]      got_cnt;
    int              got_lat;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmb_vecmem #(.ELEM_W(EW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_mode(req_mode), .req_lane_en(req_lane_en),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .cycle_count(cycle_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [1:0] mode, input logic [3:0] en,
                          input int a0, input int a1, input int a2, input int a3,
                          input logic [4*EW-1:0] wd);
        @(negedge clk);
        req_write   = wr;
        req_mode    = mode;
        req_lane_en = en;
        req_addr    = {AW'(a3), AW'(a2), AW'(a1), AW'(a0)};
        req_wdata   = wd;
        req_valid   = 1'b1;
        got_lat = 0;
        do begin
            @(posedge clk);
            got_lat++;
            @(negedge clk);
        end while (!req_ready && got_lat < 40);
        got_data  = rd_data;
        got_valid = rd_valid;
        got_cnt   = cycle_count;
        req_valid = 1'b0;
    endtask

    task automatic do_write(input string req, input logic [1:0] mode, input logic [3:0] en,
                            input int a0, input int a1, input int a2, input int a3,
                            input logic [4*EW-1:0] wd, input int exp_cnt);
        int ad [4];
        ad = '{a0, a1, a2, a3};
        access(1'b1, mode, en, a0, a1, a2, a3, wd);
        for (int l = 0; l < 4; l++)
            if (en[l]) model[ad[l]] = wd[l*EW +: EW];
        chk(got_cnt == 3'(exp_cnt), req, "write cycle_count", got_cnt, exp_cnt);
        chk(got_lat == exp_cnt + 2, "R2", "write latency", got_lat, exp_cnt + 2);
        chk(got_valid == 1'b0, "R3", "rd_valid on write", got_valid, 0);
    endtask

    task automatic do_read(input string req, input logic [1:0] mode, input logic [3:0] en,
                           input int a0, input int a1, input int a2, input int a3,
                           input int exp_cnt);
        int ad [4];
        logic [EW-1:0] e;
        ad = '{a0, a1, a2, a3};
        access(1'b0, mode, en, a0, a1, a2, a3, '0);
        for (int l = 0; l < 4; l++) begin
            e = en[l] ? model[ad[l]] : '0;
            chk(got_data[l*EW +: EW] == e, req, $sformatf("read lane %0d", l),
                got_data[l*EW +: EW], e);
        end
        chk(got_cnt == 3'(exp_cnt), req, "read cycle_count", got_cnt, exp_cnt);
        chk(got_lat == exp_cnt + 2, "R2", "read latency", got_lat, exp_cnt + 2);
        chk(got_valid == 1'b1, "R3", "rd_valid on read", got_valid, 1);
    endtask

    function automatic logic [4*EW-1:0] fill_data(input int base, input int k);
        return {EW'(base + 4*k*3 + 9), EW'(base + 4*k*3 + 6),
                EW'(base + 4*k*3 + 3), EW'(base + 4*k*3)};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_mode = 2'd0;
        req_lane_en = '0; req_addr = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b0, "R1", "ready in reset", req_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b0, "R1", "ready after reset", req_ready, 0);
        chk(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
        chk(cycle_count == 3'd0, "R1", "count after reset", cycle_count, 0);
    endtask

    task automatic t_fill(input logic [1:0] mode, input int base, input string req);
        for (int k = 0; k < DEPTH/4; k++)
            do_write(req, mode, 4'hF, 4*k, 4*k+1, 4*k+2, 4*k+3, fill_data(base, k), 1);
    endtask

    task automatic t_interleave();
        do_read("R6", 2'd1, 4'hF, 4, 5, 6, 7, 1);
        do_read("R6", 2'd1, 4'hF, 5, 6, 7, 8, 1);
        do_read("R6", 2'd1, 4'hF, 2, 6, 10, 14, 4);
        do_read("R3", 2'd1, 4'hF, 15, 3, 8, 1, 2);
        do_read("R6", 2'd1, 4'hF, 17, 18, 19, 20, 1);
    endtask

    task automatic t_single();
        do_read("R5", 2'd0, 4'hF, 8, 9, 10, 11, 1);
        do_read("R5", 2'd0, 4'hF, 1, 5, 9, 13, 4);
        do_read("R5", 2'd0, 4'hF, 1, 2, 3, 4, 2);
    endtask

    task automatic t_enable();
        do_write("R8", 2'd1, 4'b0101, 20, 21, 22, 23, {16'hD3D3, 16'hC2C2, 16'hB1B1, 16'hA0A0}, 1);
        do_read("R8", 2'd1, 4'hF, 20, 21, 22, 23, 1);
        do_write("R8", 2'd1, 4'b0001, 0, 4, 8, 12, {16'h3333, 16'h2222, 16'h1111, 16'h7E57}, 1);
        do_read("R8", 2'd1, 4'hF, 0, 4, 8, 12, 4);
        do_read("R8", 2'd1, 4'b0010, 30, 31, 32, 33, 1);
        do_read("R8", 2'd1, 4'b0000, 1, 2, 3, 4, 0);
    endtask

    task automatic t_dup();
        do_write("R9", 2'd1, 4'b1010, 0, 9, 0, 9, {16'hBEEF, 16'h0000, 16'hCAFE, 16'h0000}, 2);
        chk(model[9] == 16'hBEEF, "R9", "model order", model[9], 16'hBEEF);
        do_read("R9", 2'd1, 4'b0001, 9, 0, 0, 0, 1);
    endtask

    task automatic t_hold();
        do_read("R4", 2'd1, 4'hF, 3, 7, 11, 15, 4);
        repeat (3) @(negedge clk);
        chk(cycle_count == 3'd4, "R4", "count held while idle", cycle_count, 4);
        chk(req_ready == 1'b0, "R2", "ready low while idle", req_ready, 0);
    endtask

    task automatic t_permute();
        t_fill(2'd2, 16'h5000, "R7");
        do_read("R7", 2'd2, 4'hF, 12, 13, 14, 15, 1);
        do_read("R7", 2'd2, 4'hF, 1, 5, 9, 13, 1);
        do_read("R7", 2'd2, 4'hF, 3, 7, 11, 15, 1);
        do_read("R7", 2'd3, 4'hF, 34, 38, 42, 46, 1);
        do_read("R7", 2'd2, 4'hF, 1, 2, 3, 4, 2);
        do_read("R7", 2'd2, 4'hF, 63, 59, 55, 51, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_fill(2'd1, 16'h1000, "R6");
        t_interleave();
        t_single();
        t_enable();
        t_dup();
        t_hold();
        t_permute();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule